// File: doc/BRIEF.md
# Receive-Calibration Saturation Scanner

After memory training has finished, this block examines the receive-calibration results held in the memory PHY. It looks for data lines whose calibration has run to opposite rails. The block does this by itself: one start pulse makes it walk a fixed, strided window of PHY registers through a simple single-outstanding read port. It fetches one 32-bit word at a time and holds the address until the PHY side returns the data with a strobe.

Each word carries two packed calibration fields. Each field is a pair of 6-bit codes, one for the down direction and one for the up direction. A field whose codes sit at opposite extremes marks a broken data line. The scanner records every such line in a 64-bit failure mask. A parallel 64-bit direction mask tells which way each failing line saturated. A summary flag is raised if any line failed. A one-cycle done pulse marks the moment the results are final. Boot firmware or a training sequencer uses those results to decide whether the memory interface is usable.

Top module: `calib_sat_scan`

## Requirements
- R1: While reset is high and on the first cycle after it, rd_valid_o, done_o and any_fail_o are 0, and fail_mask_o and dir_mask_o are all zeros.
- R2: A start_i pulse accepted while no scan is running clears fail_mask_o, dir_mask_o and any_fail_o by the following cycle. It also raises rd_valid_o with the first address.
- R3: A scan makes exactly 32 reads. Slice s (0..7) uses the four consecutive addresses s*128+34 through s*128+37. Reads go slice by slice, with increasing address inside a slice.
- R4: While rd_valid_o is high and rd_ack_i is low, rd_valid_o stays high and rd_addr_o does not change. The address advances only after a cycle with both high.
- R5: In the k-th read of a scan (k = 0..31), bits [11:0] describe data line 2k and bits [27:16] describe line 2k+1. In each 12-bit field the low 6 bits are the down code and the next 6 bits are the up code.
- R6: A field with down code 0 and up code 63 sets its line's bit in fail_mask_o and sets the same bit of dir_mask_o to 1.
- R7: A field with up code 0 and down code 63 sets its line's bit in fail_mask_o and leaves the same bit of dir_mask_o at 0.
- R8: Any other code pair leaves the line's bits at 0. Data bits [15:12] and [31:28] have no effect on the result.
- R9: done_o is high for exactly one cycle, the cycle after the transfer of the 32nd read. rd_valid_o is low in that cycle, and the masks are final then.
- R10: any_fail_o is 1 exactly when at least one bit of fail_mask_o is 1.
- R11: A start_i pulse during a running scan is ignored. The scan neither restarts nor clears its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a scan (single-cycle pulse) |
| rd_addr_o | output | 10 | PHY register index being requested |
| rd_valid_o | output | 1 | Read request pending |
| rd_data_i | input | 32 | Register contents returned by the PHY side |
| rd_ack_i | input | 1 | Data valid strobe; completes the pending read |
| done_o | output | 1 | One-cycle pulse: scan complete |
| any_fail_o | output | 1 | At least one data line saturated |
| fail_mask_o | output | 64 | One bit per data line, set on saturation |
| dir_mask_o | output | 64 | For failing lines: 1 = up-rail failure, 0 = down-rail failure |

## Verification
A slip in the slice or register counter shows on rd_addr_o at the very next request. Because the PHY model answers with variable wait states, the address is compared in every waiting cycle, and a counter that moves without a strobe is caught in the cycle it moves. A misplaced line index or a swapped down/up decode only shows at the done pulse, as mask bits at the wrong position or with the wrong direction. For that reason the stimulus patterns put a distinct failure class on neighbouring lines, with one lone failure on the last line. A control state that fails to ignore a second start or to clear old results shows as a restarted address sequence, or as stale bits in the masks of the next scan.

// File: rtl/calib_scan_pkg.sv
package calib_scan_pkg;

  // Scan controller states
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_READ = 1'b1
  } scan_state_t;

  // Classification of one packed calibration field
  typedef struct packed {
    logic hit;     // field saturated at opposite rails
    logic up_dir;  // 1: up rail failure, 0: down rail failure
  } sat_flag_t;

endpackage

// File: rtl/cs_addr_seq.sv
module cs_addr_seq #(
  parameter int NUM_SLICES     = 8,
  parameter int REGS_PER_SLICE = 4,
  parameter int SLICE_STRIDE   = 128,
  parameter int SLICE_BASE     = 34,
  parameter int ADDR_W         = 10,
  parameter int ORD_W          = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ORD_W-1:0]  ord_o,
  output logic              last_o
);

  localparam int SL_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
  localparam int RG_W     = (REGS_PER_SLICE > 1) ? $clog2(REGS_PER_SLICE) : 1;
  localparam int JUMP     = SLICE_STRIDE - (REGS_PER_SLICE - 1);

  logic [SL_W-1:0]   slice_q;
  logic [RG_W-1:0]   sub_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sub_end;

  assign sub_end = (sub_q == RG_W'(REGS_PER_SLICE - 1));

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      slice_q <= '0;
      sub_q   <= '0;
      addr_q  <= ADDR_W'(SLICE_BASE);
    end else if (step_i) begin
      if (sub_end) begin
        sub_q   <= '0;
        slice_q <= slice_q + 1'b1;
        addr_q  <= addr_q + ADDR_W'(JUMP);
      end else begin
        sub_q   <= sub_q + 1'b1;
        addr_q  <= addr_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign ord_o  = ORD_W'(int'(slice_q) * REGS_PER_SLICE + int'(sub_q));
  assign last_o = sub_end && (slice_q == SL_W'(NUM_SLICES - 1));

  // Address and ordinal advance together: a step inside a slice moves both by one
  AST_STEP_INSIDE_SLICE: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i && !sub_end) |=> (addr_o == $past(addr_o) + 1'b1)); // R3

endmodule

// File: rtl/cs_field_check.sv
module cs_field_check
  import calib_scan_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int FIELDS_PER_REG = 2,
  parameter int FIELD_SPACING  = 16,
  parameter int CODE_W         = 6
) (
  input  logic [DATA_W-1:0]       word_i,
  output sat_flag_t [FIELDS_PER_REG-1:0] flag_o
);

  localparam int PAIR_W = 2 * CODE_W;

  logic unused_word_bits;
  assign unused_word_bits = ^word_i;

  for (genvar f = 0; f < FIELDS_PER_REG; f++) begin : g_field
    logic [CODE_W-1:0] dn_code;
    logic [CODE_W-1:0] up_code;
    logic              rail_up;
    logic              rail_dn;

    assign dn_code = word_i[f*FIELD_SPACING +: CODE_W];
    assign up_code = word_i[f*FIELD_SPACING + CODE_W +: CODE_W];

    // Down code pinned low while up code pinned high, and the mirror case
    assign rail_up = (dn_code == '0) && (up_code == '1);
    assign rail_dn = (up_code == '0) && (dn_code == '1);

    assign flag_o[f].hit    = rail_up | rail_dn;
    assign flag_o[f].up_dir = rail_up;
  end

  if (FIELD_SPACING < PAIR_W) begin : g_bad_spacing
    initial $error("field spacing narrower than a code pair");
  end

endmodule

// File: rtl/cs_result_acc.sv
module cs_result_acc
  import calib_scan_pkg::*;
#(
  parameter int FIELDS_PER_REG = 2,
  parameter int NUM_LINES      = 64,
  parameter int ORD_W          = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear_i,
  input  logic                          upd_i,
  input  logic [ORD_W-1:0]              ord_i,
  input  sat_flag_t [FIELDS_PER_REG-1:0] flag_i,
  output logic [NUM_LINES-1:0]          fail_o,
  output logic [NUM_LINES-1:0]          dir_o,
  output logic                          any_o
);

  logic [NUM_LINES-1:0] fail_q;
  logic [NUM_LINES-1:0] dir_q;
  logic                 any_q;
  logic                 word_hit;

  always_comb begin
    word_hit = 1'b0;
    for (int f = 0; f < FIELDS_PER_REG; f++) word_hit = word_hit | flag_i[f].hit;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      fail_q <= '0;
      dir_q  <= '0;
      any_q  <= 1'b0;
    end else if (upd_i) begin
      for (int n = 0; n < NUM_LINES; n++) begin
        if ((ord_i == ORD_W'(n / FIELDS_PER_REG)) && flag_i[n % FIELDS_PER_REG].hit) begin
          fail_q[n] <= 1'b1;
          dir_q[n]  <= flag_i[n % FIELDS_PER_REG].up_dir;
        end
      end
      any_q <= any_q | word_hit;
    end
  end

  assign fail_o = fail_q;
  assign dir_o  = dir_q;
  assign any_o  = any_q;

  AST_DIR_ONLY_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (dir_q & ~fail_q) == '0); // R6

  AST_SUMMARY_MATCHES_MASK: assert property (@(posedge clk) disable iff (rst)
    any_q == (|fail_q)); // R10

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!clear_i) |=> ((fail_q & $past(fail_q)) == $past(fail_q))); // R5

endmodule

// File: rtl/calib_sat_scan.sv
module calib_sat_scan
  import calib_scan_pkg::*;
#(
  parameter int NUM_SLICES     = 8,
  parameter int REGS_PER_SLICE = 4,
  parameter int SLICE_STRIDE   = 128,
  parameter int SLICE_BASE     = 34,
  parameter int DATA_W         = 32,
  parameter int FIELDS_PER_REG = 2,
  parameter int FIELD_SPACING  = 16,
  parameter int CODE_W         = 6,
  parameter int ADDR_W         = $clog2(SLICE_BASE + (NUM_SLICES - 1) * SLICE_STRIDE
                                        + REGS_PER_SLICE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic                rd_valid_o,
  input  logic [DATA_W-1:0]   rd_data_i,
  input  logic                rd_ack_i,
  output logic                done_o,
  output logic                any_fail_o,
  output logic [NUM_SLICES*REGS_PER_SLICE*FIELDS_PER_REG-1:0] fail_mask_o,
  output logic [NUM_SLICES*REGS_PER_SLICE*FIELDS_PER_REG-1:0] dir_mask_o
);

  localparam int NUM_READS = NUM_SLICES * REGS_PER_SLICE;
  localparam int NUM_LINES = NUM_READS * FIELDS_PER_REG;
  localparam int ORD_W     = (NUM_READS > 1) ? $clog2(NUM_READS) : 1;

  scan_state_t state_q;
  logic        valid_q;
  logic        done_q;
  logic        accept;
  logic        xfer;
  logic        last_rd;
  logic [ORD_W-1:0] ord;
  sat_flag_t [FIELDS_PER_REG-1:0] flags;

  assign accept = start_i && (state_q == SCAN_IDLE);
  assign xfer   = valid_q && rd_ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SCAN_IDLE;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SCAN_IDLE: if (accept) begin
          state_q <= SCAN_READ;
          valid_q <= 1'b1;
        end
        SCAN_READ: if (xfer && last_rd) begin
          state_q <= SCAN_IDLE;
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  cs_addr_seq #(
    .NUM_SLICES     (NUM_SLICES),
    .REGS_PER_SLICE (REGS_PER_SLICE),
    .SLICE_STRIDE   (SLICE_STRIDE),
    .SLICE_BASE     (SLICE_BASE),
    .ADDR_W         (ADDR_W),
    .ORD_W          (ORD_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .step_i  (xfer),
    .addr_o  (rd_addr_o),
    .ord_o   (ord),
    .last_o  (last_rd)
  );

  cs_field_check #(
    .DATA_W         (DATA_W),
    .FIELDS_PER_REG (FIELDS_PER_REG),
    .FIELD_SPACING  (FIELD_SPACING),
    .CODE_W         (CODE_W)
  ) u_chk (
    .word_i (rd_data_i),
    .flag_o (flags)
  );

  cs_result_acc #(
    .FIELDS_PER_REG (FIELDS_PER_REG),
    .NUM_LINES      (NUM_LINES),
    .ORD_W          (ORD_W)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .upd_i   (xfer),
    .ord_i   (ord),
    .flag_i  (flags),
    .fail_o  (fail_mask_o),
    .dir_o   (dir_mask_o),
    .any_o   (any_fail_o)
  );

  assign rd_valid_o = valid_q;
  assign done_o     = done_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ack_i) |=> (rd_valid_o && $stable(rd_addr_o))); // R4

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> ((int'(rd_addr_o) % SLICE_STRIDE) >= SLICE_BASE &&
                    (int'(rd_addr_o) % SLICE_STRIDE) <  SLICE_BASE + REGS_PER_SLICE)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !rd_valid_o); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !rd_valid_o) |=> (fail_mask_o == '0 && !any_fail_o && rd_valid_o)); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start_i && rd_valid_o && !rd_ack_i) |=> $stable(rd_addr_o)); // R11

endmodule

// File: tb/calib_sat_scan_tb.sv
`timescale 1ns/1ps
module calib_sat_scan_tb;

  localparam int NREAD = 32;
  localparam int LINES = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic [9:0]  rd_addr_o;
  logic        rd_valid_o;
  logic        done_o;
  logic        any_fail_o;
  logic [63:0] fail_mask_o;
  logic [63:0] dir_mask_o;

  calib_sat_scan u_dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rd_addr_o   (rd_addr_o),
    .rd_valid_o  (rd_valid_o),
    .rd_data_i   (rd_data_i),
    .rd_ack_i    (rd_ack_i),
    .done_o      (done_o),
    .any_fail_o  (any_fail_o),
    .fail_mask_o (fail_mask_o),
    .dir_mask_o  (dir_mask_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cur_pat = 0;
  int ord = 0;
  int wait_cnt = 0;
  int scans_done = 0;
  bit prev_done = 1'b0;
  bit prev_ack = 1'b0;

  logic [9:0]   addr_q[$];
  logic [128:0] res_q[$];
  string        lbl_q[$];

  // 0: clean, 1: up-rail failure, 2: down-rail failure
  function automatic int kind_of(int p, int n);
    case (p)
      1: return 1;
      2: return 2;
      3: return (n % 4 == 0) ? 1 : ((n % 4 == 1) ? 2 : 0);
      4: return (n == LINES - 1) ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  // 16-bit slice of a word: down code [5:0], up code [11:6], junk [15:12]
  function automatic logic [15:0] field_val(int p, int n);
    int k;
    k = kind_of(p, n);
    if (k == 1) return (n % 2 == 1) ? 16'hFFC0 : 16'h0FC0;
    if (k == 2) return (n % 4 >= 2) ? 16'hA03F : 16'h003F;
    case (p)
      3: return (n % 4 == 2) ? 16'h0F80 : 16'h0FFF;
      4: return 16'h5FBF;
      5: return (n % 3 == 0) ? 16'h0FC1 : ((n % 3 == 1) ? 16'h007F : 16'hF040);
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [31:0] word_for(int p, int k);
    return {field_val(p, 2*k+1), field_val(p, 2*k)};
  endfunction

  task automatic check(bit ok, string req, string what, logic [128:0] act, logic [128:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard driver: pushes expected reads and result, then starts the scan
  task automatic run_scan(int p, string lbl, bit poke);
    logic [63:0] ef;
    logic [63:0] ed;
    int target;
    ef = '0;
    ed = '0;
    for (int n = 0; n < LINES; n++) begin
      if (kind_of(p, n) != 0) ef[n] = 1'b1;
      if (kind_of(p, n) == 1) ed[n] = 1'b1;
    end
    for (int k = 0; k < NREAD; k++) addr_q.push_back(10'(34 + (k / 4) * 128 + (k % 4)));
    res_q.push_back({|ef, ed, ef});
    lbl_q.push_back(lbl);
    cur_pat  = p;
    ord      = 0;
    wait_cnt = p % 2;
    target   = scans_done + 1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(fail_mask_o == '0 && dir_mask_o == '0 && !any_fail_o && rd_valid_o, "R2",
          "clear on start", {rd_valid_o, any_fail_o, fail_mask_o}, {2'b10, 64'h0});
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(rd_valid_o == 1'b1, "R11", "scan keeps running after second start",
            129'(rd_valid_o), 129'(1));
    end
    while (scans_done < target) @(negedge clk);
  endtask

  // PHY model and monitor
  initial begin
    forever begin
      @(negedge clk);
      rd_ack_i = 1'b0;
      if (done_o) begin
        logic [128:0] exp;
        string lb;
        check(!prev_done, "R9", "done lasts one cycle", 129'(prev_done), 129'(0));
        check(!rd_valid_o, "R9", "no request while done", 129'(rd_valid_o), 129'(0));
        if (res_q.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 129'(1), 129'(0));
        end else begin
          exp = res_q.pop_front();
          lb  = lbl_q.pop_front();
          check(addr_q.size() == 0, "R3", "read count", 129'(addr_q.size()), 129'(0));
          check({dir_mask_o, fail_mask_o} == exp[127:0], lb, "masks {dir,fail}",
                129'({dir_mask_o, fail_mask_o}), 129'(exp[127:0]));
          check(any_fail_o == exp[128], "R10", "summary flag",
                129'(any_fail_o), 129'(exp[128]));
        end
        scans_done++;
      end
      prev_done = done_o;
      if (rd_valid_o) begin
        if (addr_q.size() == 0) begin
          check(1'b0, "R3", "request beyond window", 129'(rd_addr_o), 129'(0));
        end else begin
          check(rd_addr_o == addr_q[0], prev_ack ? "R3" : "R4", "read address",
                129'(rd_addr_o), 129'(addr_q[0]));
          if (wait_cnt == 0) begin
            rd_ack_i  = 1'b1;
            rd_data_i = word_for(cur_pat, ord);
            void'(addr_q.pop_front());
            ord++;
            wait_cnt = (ord * 7 + cur_pat) % 3;
          end else begin
            wait_cnt--;
            rd_data_i = 32'h0FC0_0FC0;
          end
        end
      end
      prev_ack = rd_ack_i;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!rd_valid_o && !done_o && !any_fail_o && fail_mask_o == '0 && dir_mask_o == '0,
          "R1", "outputs in reset", {rd_valid_o, done_o, any_fail_o}, 129'(0));
    rst = 1'b0;
    @(negedge clk);
    check(!rd_valid_o && !done_o && !any_fail_o && fail_mask_o == '0 && dir_mask_o == '0,
          "R1", "outputs after reset", {rd_valid_o, done_o, any_fail_o}, 129'(0));
    run_scan(1, "R6", 1'b0);
    run_scan(0, "R8", 1'b0);
    run_scan(2, "R7", 1'b0);
    run_scan(3, "R5", 1'b1);
    run_scan(4, "R7", 1'b0);
    run_scan(5, "R8", 1'b0);
    repeat (4) @(negedge clk);
    check(!rd_valid_o && !done_o, "R9", "idle after last scan",
          {rd_valid_o, done_o}, 129'(0));
    finish_run();
  end

endmodule